// File: doc/BRIEF.md
# Keystream-Whitened Slot Transmitter

This block sends response frames from a tag back to a reader. It uses on/off subcarrier modulation, and each bit sits in a slot of fixed length. The caller pulses `start_i` at the reference end of the previous frame. The block then holds the modulation low for a wait gap. The gap length depends on the frame kind: a data frame uses one wait and a one-bit acknowledge uses another. After the gap the block shifts out the bits, one slot each.

Data bits go out from bit 0 of the frame word upward. Each bit is XORed with a keystream bit that comes from an external generator. The acknowledge is a single 1 that is not whitened.

The block pulses `ks_step_o` so that the external keystream stays aligned with every elapsed bit period. For a wait of W slots it gives W−1 steps during the gap, then one step at the end of every transmitted bit. When the last slot ends, the modulation is forced low and a one-cycle done pulse marks the new frame end. A following frame may be started in that same cycle.

Top module: `slot_keyed_tx`

## Requirements
- R1: After reset, `mod_o`, `busy_o`, `done_o` and `ks_step_o` are all 0.
- R2: A frame is accepted only when `busy_o` is 0. A `start_i` pulse while busy has no effect on the modulation, the timing or the number of keystream steps of the frame in progress.
- R3: A data frame is accepted at clock edge t0. Its gap lasts FRAME_WAIT_SLOTS×BIT_CYCLES cycles, so bit 0 appears after edge t0+FRAME_WAIT_SLOTS×BIT_CYCLES. During the gap, `ks_step_o` pulses FRAME_WAIT_SLOTS−1 times, each pulse one cycle long in the last cycle of a gap slot.
- R4: Data bit k is `word_i[k]` XOR `ks_bit_i`, sent in order k = 0, 1, … . `ks_step_o` pulses in the last cycle of every bit slot.
- R5: With `ack_i`=1 the gap is ACK_WAIT_SLOTS slots with ACK_WAIT_SLOTS−1 steps. One bit of value 1 follows, not whitened, and it is followed by one step. `word_i` and `len_i` are ignored.
- R6: Each bit occupies exactly BIT_CYCLES cycles. The modulation is held for the whole slot and is not released between consecutive bits.
- R7: At the edge that ends the last slot, `mod_o` goes to 0, `busy_o` goes to 0 and `done_o` is high for exactly one cycle. A start in that cycle is accepted.
- R8: With `len_i`=0, no bit is sent: done follows the gap, with FRAME_WAIT_SLOTS−1 steps. A `len_i` above MAX_LEN is treated as MAX_LEN.
- R9: `mod_o` is 0 whenever no bit slot is in progress, both when idle and during the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame; marks the reference frame end |
| ack_i | input | 1 | 1: send the acknowledge bit; 0: send a data frame |
| word_i | input | MAX_LEN (16) | Frame bits, bit 0 sent first |
| len_i | input | LEN_W (5) | Number of data bits |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_step_o | output | 1 | Advance the keystream at the next edge |
| mod_o | output | 1 | Subcarrier modulation enable |
| busy_o | output | 1 | A frame is in its gap or bit phase |
| done_o | output | 1 | One-cycle pulse at the new frame end |

## Verification
The bench runs a full 16-bit data frame whose bit pattern alternates irregularly. This shows that the bits go out in order and that the keystream is applied per bit. A short 5-bit frame then checks that the end timing follows the length, not the maximum. Two acknowledges, one with a nonzero word and one with zero, show that the acknowledge ignores the word and skips whitening. A zero-length frame, an over-long length and a start injected mid-frame separate the clamp, the empty-frame path and the idle-only acceptance. Frames are chained back to back, starting in the done cycle, so a lost or extra keystream step shows up as wrong bits in the next frame.

// File: rtl/skt_pkg.sv
package skt_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_GAP  = 2'd1,
      TX_BITS = 2'd2
   } tx_state_t;
endpackage

// File: rtl/skt_slot_timer.sv
module skt_slot_timer #(
   parameter int BIT_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic run_i,
   output logic slot_end_o
);
   localparam int CYC_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BIT_CYCLES - 1);

   logic [CYC_W-1:0] cyc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cyc_q <= '0;
      end else if (load_i) begin
         cyc_q <= '0;
      end else if (run_i) begin
         cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
      end
   end

   assign slot_end_o = run_i && (cyc_q == CYC_LAST);
endmodule

// File: rtl/skt_sequencer.sv
module skt_sequencer
   import skt_pkg::*;
#(
   parameter int MAX_LEN          = 16,
   parameter int FRAME_WAIT_SLOTS = 6,
   parameter int ACK_WAIT_SLOTS   = 3,
   parameter int LEN_W            = $clog2(MAX_LEN + 1),
   parameter int IDX_W            = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               ack_i,
   input  logic [MAX_LEN-1:0] word_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic               slot_end_i,
   output logic               load_o,
   output logic               busy_o,
   output tx_state_t          st_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               ack_o,
   output logic [MAX_LEN-1:0] word_o,
   output logic               done_o,
   output logic               ks_step_o
);
   localparam logic [IDX_W-1:0] FW_LAST = IDX_W'(FRAME_WAIT_SLOTS - 1);
   localparam logic [IDX_W-1:0] AW_LAST = IDX_W'(ACK_WAIT_SLOTS - 1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

   tx_state_t          st_q;
   logic [IDX_W-1:0]   idx_q;
   logic [LEN_W-1:0]   len_q;
   logic               ack_q;
   logic [MAX_LEN-1:0] word_q;
   logic               done_q;
   logic               accept;
   logic [LEN_W-1:0]   len_eff;
   logic [IDX_W-1:0]   gap_last;
   logic [IDX_W-1:0]   bit_last;

   assign accept   = start_i && (st_q == TX_IDLE);
   assign len_eff  = (len_i > LEN_MAX) ? LEN_MAX : len_i;
   assign gap_last = ack_q ? AW_LAST : FW_LAST;
   assign bit_last = ack_q ? '0 : (IDX_W'(len_q) - IDX_W'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= TX_IDLE;
         idx_q  <= '0;
         len_q  <= '0;
         ack_q  <= 1'b0;
         word_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            st_q   <= TX_GAP;
            idx_q  <= '0;
            ack_q  <= ack_i;
            word_q <= word_i;
            len_q  <= len_eff;
         end else if (slot_end_i) begin
            unique case (st_q)
               TX_GAP: begin
                  if (idx_q == gap_last) begin
                     idx_q <= '0;
                     if (ack_q || (len_q != '0)) begin
                        st_q <= TX_BITS;
                     end else begin
                        st_q   <= TX_IDLE;
                        done_q <= 1'b1;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               TX_BITS: begin
                  if (idx_q == bit_last) begin
                     idx_q  <= '0;
                     st_q   <= TX_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
               default: st_q <= TX_IDLE;
            endcase
         end
      end
   end

   assign load_o    = accept;
   assign busy_o    = (st_q != TX_IDLE);
   assign st_o      = st_q;
   assign idx_o     = idx_q;
   assign ack_o     = ack_q;
   assign word_o    = word_q;
   assign done_o    = done_q;
   assign ks_step_o = slot_end_i &&
                      (((st_q == TX_GAP) && (idx_q != gap_last)) || (st_q == TX_BITS));
endmodule

// File: rtl/skt_bit_mux.sv
module skt_bit_mux
   import skt_pkg::*;
#(
   parameter int MAX_LEN = 16,
   parameter int IDX_W   = 5
) (
   input  tx_state_t          st_i,
   input  logic               ack_i,
   input  logic [MAX_LEN-1:0] word_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic               ks_bit_i,
   output logic               mod_o
);
   logic [MAX_LEN-1:0] shifted;
   logic               raw_bit;
   logic               key_bit;

   assign shifted = word_i >> idx_i;
   assign raw_bit = ack_i ? 1'b1 : shifted[0];
   assign key_bit = ack_i ? 1'b0 : ks_bit_i;
   assign mod_o   = (st_i == TX_BITS) && (raw_bit ^ key_bit);
endmodule

// File: rtl/slot_keyed_tx.sv
module slot_keyed_tx
   import skt_pkg::*;
#(
   parameter int BIT_CYCLES       = 8,
   parameter int MAX_LEN          = 16,
   parameter int FRAME_WAIT_SLOTS = 6,
   parameter int ACK_WAIT_SLOTS   = 3,
   parameter int LEN_W            = $clog2(MAX_LEN + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               ack_i,
   input  logic [MAX_LEN-1:0] word_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic               ks_bit_i,
   output logic               ks_step_o,
   output logic               mod_o,
   output logic               busy_o,
   output logic               done_o
);
   localparam int CNT_MAX_A = (FRAME_WAIT_SLOTS > ACK_WAIT_SLOTS) ? FRAME_WAIT_SLOTS : ACK_WAIT_SLOTS;
   localparam int CNT_MAX   = (CNT_MAX_A > MAX_LEN) ? CNT_MAX_A : MAX_LEN;
   localparam int IDX_W     = $clog2(CNT_MAX + 1);

   if (BIT_CYCLES < 2) begin : g_bad_bit_cycles
      $error("BIT_CYCLES must be at least 2");
   end
   if (FRAME_WAIT_SLOTS < 1 || ACK_WAIT_SLOTS < 1) begin : g_bad_wait
      $error("wait slot counts must be at least 1");
   end
   if (MAX_LEN < 1 || LEN_W < $clog2(MAX_LEN + 1)) begin : g_bad_len
      $error("MAX_LEN must be at least 1 and LEN_W must hold it");
   end

   logic               load;
   logic               slot_end;
   tx_state_t          st;
   logic [IDX_W-1:0]   idx;
   logic               ack_q;
   logic [MAX_LEN-1:0] word_q;

   skt_slot_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .run_i      (busy_o),
      .slot_end_o (slot_end)
   );

   skt_sequencer #(
      .MAX_LEN          (MAX_LEN),
      .FRAME_WAIT_SLOTS (FRAME_WAIT_SLOTS),
      .ACK_WAIT_SLOTS   (ACK_WAIT_SLOTS),
      .LEN_W            (LEN_W),
      .IDX_W            (IDX_W)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .ack_i      (ack_i),
      .word_i     (word_i),
      .len_i      (len_i),
      .slot_end_i (slot_end),
      .load_o     (load),
      .busy_o     (busy_o),
      .st_o       (st),
      .idx_o      (idx),
      .ack_o      (ack_q),
      .word_o     (word_q),
      .done_o     (done_o),
      .ks_step_o  (ks_step_o)
   );

   skt_bit_mux #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_mux (
      .st_i     (st),
      .ack_i    (ack_q),
      .word_i   (word_q),
      .idx_i    (idx),
      .ks_bit_i (ks_bit_i),
      .mod_o    (mod_o)
   );
endmodule

// File: rtl/slot_keyed_tx_chk.sv
module slot_keyed_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic mod,
   input logic done,
   input logic ks_step
);
   assert_mod_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mod);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> !busy);

   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_step_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ks_step |-> busy);

   assert_step_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ks_step |=> !ks_step);
endmodule

bind slot_keyed_tx slot_keyed_tx_chk u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .start   (start_i),
   .busy    (busy_o),
   .mod     (mod_o),
   .done    (done_o),
   .ks_step (ks_step_o)
);

// File: tb/slot_keyed_tx_tb_top.sv
module slot_keyed_tx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int BC         = 8;
   localparam int MAXL       = 16;
   localparam int FW         = 6;
   localparam int AW         = 3;
   localparam int LW         = $clog2(MAXL + 1);

   typedef struct {
      int    when;
      logic  mod;
      logic  done;
      string tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            ack = 1'b0;
   logic [MAXL-1:0] word = '0;
   logic [LW-1:0]   len = '0;
   logic            ks_step, mod, busy, done;
   logic [15:0]     lfsr = 16'hACE1;
   logic            step_pend = 1'b0;
   int              steps = 0;
   int              cyc_n = 0;
   int              n_tests = 0;
   int              n_fail = 0;
   exp_t            q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   slot_keyed_tx #(
      .BIT_CYCLES(BC), .MAX_LEN(MAXL), .FRAME_WAIT_SLOTS(FW), .ACK_WAIT_SLOTS(AW)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ack_i(ack), .word_i(word),
      .len_i(len), .ks_bit_i(lfsr[0]), .ks_step_o(ks_step), .mod_o(mod),
      .busy_o(busy), .done_o(done)
   );

   function automatic logic [15:0] lfsr_next(input logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   always @(posedge clk) begin
      cyc_n <= cyc_n + 1;
      if (step_pend) begin
         lfsr  <= lfsr_next(lfsr);
         steps <= steps + 1;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc_n);
      end
   endtask

   // monitor: sample outputs mid-cycle and compare against queued expectations
   always @(negedge clk) begin
      step_pend <= ks_step;
      while (q.size() > 0 && q[0].when <= cyc_n) begin
         exp_t e;
         e = q.pop_front();
         if (e.when < cyc_n) begin
            check({e.tag, " missed sample"}, cyc_n, e.when);
         end else begin
            check({e.tag, " mod"}, int'(mod), int'(e.mod));
            check({e.tag, " done"}, int'(done), int'(e.done));
         end
      end
   end

   function automatic void push(input int when, input logic m, input logic d, input string tag);
      exp_t e;
      e.when = when; e.mod = m; e.done = d; e.tag = tag;
      q.push_back(e);
   endfunction

   // driver: called at a negedge; issues a frame and queues its expected waveform
   task automatic send(input logic is_ack, input logic [MAXL-1:0] w, input int l, input bit inject);
      int          t0, wait_s, nbits, t_end, base;
      logic [15:0] s;
      string       btag;
      start = 1'b1; ack = is_ack; word = w; len = LW'(l);
      t0     = cyc_n + 1;
      base   = steps;
      wait_s = is_ack ? AW : FW;
      nbits  = is_ack ? 1 : ((l > MAXL) ? MAXL : l);
      t_end  = t0 + (wait_s + nbits) * BC;
      btag   = is_ack ? "R5" : ((l > MAXL || l == 0) ? "R8" : "R4");
      s = lfsr;
      for (int i = 0; i < wait_s - 1; i++) s = lfsr_next(s);
      push(t0, 1'b0, 1'b0, "R9 gap start");
      push(t0 + wait_s * BC - 1, 1'b0, 1'b0, "R3 gap end");
      for (int k = 0; k < nbits; k++) begin
         logic b;
         b = is_ack ? 1'b1 : (w[k] ^ s[0]);
         s = lfsr_next(s);
         push(t0 + (wait_s + k) * BC, b, 1'b0, {btag, " bit first cycle"});
         push(t0 + (wait_s + k + 1) * BC - 1, b, 1'b0, "R6 bit last cycle");
      end
      push(t_end, 1'b0, 1'b1, "R7 frame end");
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         while (cyc_n < t0 + (wait_s + 1) * BC) @(negedge clk);
         start = 1'b1; ack = 1'b1; word = '0; len = LW'(1);
         @(negedge clk);
         start = 1'b0;
      end
      while (cyc_n < t_end) @(negedge clk);
      check(is_ack ? "R5 step count" : "R3 R4 step count", steps - base, wait_s - 1 + nbits);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset mod", int'(mod), 0);
      check("R1 reset busy", int'(busy), 0);
      check("R1 reset done", int'(done), 0);
      check("R1 reset step", int'(ks_step), 0);
      rst_n = 1'b1;
      @(negedge clk);
      send(1'b0, 16'hA5C3, 16, 1'b0);
      send(1'b0, 16'h0013, 5, 1'b0);
      send(1'b1, 16'hFFFF, 9, 1'b0);
      send(1'b0, 16'h7E81, 0, 1'b0);
      send(1'b0, 16'h3C96, 20, 1'b0);
      send(1'b0, 16'h00F0, 12, 1'b1);   // R2: start pulsed mid-frame
      send(1'b1, 16'h0000, 0, 1'b0);
      send(1'b0, 16'hFFFF, 3, 1'b0);
      repeat (3) @(negedge clk);
      check("R9 idle mod", int'(mod), 0);
      check("R2 idle busy", int'(busy), 0);
      check("R4 queue drained", q.size(), 0);
      summary();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end
endmodule